// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns two encoder phase signals into a 32-bit position count. It also watches a home switch and an index marker, keeps a revolution count and flags a set of events. Software sets it up and reads it back through a small map of 16-bit registers, using single-cycle read and write strobes. The phase, home and index inputs must already be synchronous to `clk` and free of glitches. Each input level is sampled at a rising clock edge. Any count, load or flag that it causes is visible right after that same edge.

In normal mode, each legal Gray-code step of the phase pair moves the count by one. In single-phase mode, A acts as a count pulse and B selects the direction. Modulo mode makes the count cycle between an initial value and a modulus. The index edge reloads the initial value. The revolution counter follows either the index edge or the modulo wraps. Flags stay set until software clears them. A flag is cleared by writing a one to its bit. Each flag has its own interrupt enable.

Register map (4-bit address): 0 config, 1 flags, 2 interrupt enables, 3 position upper half, 4 held lower half, 5 live lower half, 6 revolution, 7/8 initial value upper/lower, 9/10 modulus upper/lower, 11/12 compare upper/lower, 13 watchdog timeout, 14 held upper half. Unmapped addresses read 0.

Top module: `quad_pos_decoder`

## Requirements
- R1: After reset these all read 0: the position, the hold register, the flags, the config and the revolution count. The compare value reads 0xFFFF in both halves, and `match_out` and `irq_out` are low.
- R2: In quadrature mode (config bit 1 = 0), the phase pair {A,B} stepping 00→10→11→01→00 adds 1 per step, and the reverse order subtracts 1. Flags bit 8 reads 1 after an up count and 0 after a down count.
- R3: In quadrature mode, a change of both phases at once leaves the position unchanged and sets flag bit 6.
- R4: Config bit 0 = 1 inverts the count direction.
- R5: With config bit 1 = 1, a rising edge of A counts up when B = 0 and down when B = 1. A falling edge of A, or any change of B alone, does not count.
- R6: Config bits [3:2] pick the home edge: 0 off, 1 rising, 2 falling. The chosen edge sets flag bit 0, and the other edge does nothing.
- R7: Config bits [5:4] pick the index edge with the same encoding. The chosen edge loads the initial value into the position and sets flag bit 1. When config bit 7 = 0, it also moves the revolution count by +1 if the last count was up, or by -1 if it was down.
- R8: With config bit 6 = 1, counting up from the modulus loads the initial value and sets flag bit 4, and counting down from the initial value loads the modulus and sets flag bit 5. With bit 6 = 0, the count wraps at all-ones/zero and sets the same flags. With config bit 7 = 1, those wraps move the revolution count by +1 or -1.
- R9: With config bit 8 = 0, `match_out` is high one cycle after any cycle where position equals the compare value, and that cycle sets flag bit 3. With bit 8 = 1, `match_out` pulses for one cycle after a read of address 3, 4, 5 or 14.
- R10: A read of address 3 returns the live upper half and captures the whole position. Address 4 then returns the captured lower half.
- R11: With config bit 9 = 1, flag bit 2 is set after timeout+1 consecutive cycles with no phase change. Any phase change restarts the wait.
- R12: Writing 1 to a bit of register 1 clears that flag, and writing 0 leaves it unchanged. A flag that sets in the same cycle as it is cleared stays set.
- R13: `irq_out` is high whenever some flag bit is set and the same bit of register 2 is 1.
- R14: Writing config with bit 15 = 1 loads the initial value into the position. Bit 15 always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Phase A |
| enc_b | input | 1 | Phase B |
| home_in | input | 1 | Home switch |
| index_in | input | 1 | Index marker |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of `reg_rd` |
| match_out | output | 1 | Position match / read pulse |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-bit register width, which gives a 32-bit position. With that width, a count of 0 or 0xFFFFFFFF can be reached in a single step, so the non-modulo wrap can be tested. That same value also equals the reset compare value, so a set-and-clear collision on the compare flag comes up naturally. A small modulus window a few counts above an initial value puts both modulo wraps, and the revolution count they drive, a few steps away. A watchdog timeout of 5 keeps the expiry within a handful of idle cycles.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int unsigned NFLAG      = 7;
  localparam int unsigned CFG_W      = 10;
  localparam int unsigned DIR_BIT    = 8;
  localparam int unsigned SWINIT_BIT = 15;

  localparam int unsigned FL_HOME  = 0;
  localparam int unsigned FL_INDEX = 1;
  localparam int unsigned FL_WDOG  = 2;
  localparam int unsigned FL_CMP   = 3;
  localparam int unsigned FL_ROVR  = 4;
  localparam int unsigned FL_RUND  = 5;
  localparam int unsigned FL_SIMUL = 6;

  localparam logic [3:0] AD_CFG     = 4'd0;
  localparam logic [3:0] AD_FLAGS   = 4'd1;
  localparam logic [3:0] AD_IEN     = 4'd2;
  localparam logic [3:0] AD_POS_HI  = 4'd3;
  localparam logic [3:0] AD_HOLD_LO = 4'd4;
  localparam logic [3:0] AD_POS_LO  = 4'd5;
  localparam logic [3:0] AD_REV     = 4'd6;
  localparam logic [3:0] AD_INIT_HI = 4'd7;
  localparam logic [3:0] AD_INIT_LO = 4'd8;
  localparam logic [3:0] AD_MOD_HI  = 4'd9;
  localparam logic [3:0] AD_MOD_LO  = 4'd10;
  localparam logic [3:0] AD_CMP_HI  = 4'd11;
  localparam logic [3:0] AD_CMP_LO  = 4'd12;
  localparam logic [3:0] AD_TMO     = 4'd13;
  localparam logic [3:0] AD_HOLD_HI = 4'd14;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_NONE = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic       wdog_en;
    logic       match_on_read;
    logic       rev_from_wrap;
    logic       modulo;
    trig_mode_e index_mode;
    trig_mode_e home_mode;
    logic       single;
    logic       reverse;
  } cfg_t;

endpackage

// File: rtl/qdec_trig.sv
module qdec_trig
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig_i,
  input  trig_mode_e mode_i,
  output logic       evt_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
    case (mode_i)
      TRIG_RISE: evt_o = sig_i & ~prev_q;
      TRIG_FALL: evt_o = ~sig_i & prev_q;
      default:   evt_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  p_edge_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (sig_i != prev_q));

endmodule

// File: rtl/qdec_phase.sv
module qdec_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  input  logic b_i,
  input  logic single_i,
  input  logic reverse_i,
  output logic up_o,
  output logic dn_o,
  output logic simult_o,
  output logic activity_o
);

  logic [1:0] ab_q;
  logic [1:0] ab_d;
  logic [1:0] g_cur;
  logic [1:0] g_prev;
  logic [1:0] g_diff;
  logic       fwd;
  logic       bwd;
  logic       both;

  // Gray position: 00->0, 10->1, 11->2, 01->3
  assign g_cur  = {b_i, a_i ^ b_i};
  assign g_prev = {ab_q[0], ab_q[1] ^ ab_q[0]};
  assign g_diff = g_cur - g_prev;

  always_comb begin
    ab_d = {a_i, b_i};
    if (single_i) begin
      fwd  = a_i & ~ab_q[1] & ~b_i;
      bwd  = a_i & ~ab_q[1] &  b_i;
      both = 1'b0;
    end else begin
      fwd  = (g_diff == 2'd1);
      bwd  = (g_diff == 2'd3);
      both = (g_diff == 2'd2);
    end
    up_o       = reverse_i ? bwd : fwd;
    dn_o       = reverse_i ? fwd : bwd;
    simult_o   = both;
    activity_o = (ab_d != ab_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ab_q <= 2'b00;
    else        ab_q <= ab_d;
  end

  p_idle_nostep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({a_i, b_i} == ab_q) |-> !(up_o || dn_o || simult_o));

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int unsigned POS_W = 32,
  parameter int unsigned REV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [POS_W-1:0] init_i,
  input  logic [POS_W-1:0] mod_i,
  input  logic             mod_en_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             index_i,
  input  logic             rev_src_i,
  output logic [POS_W-1:0] pos_o,
  output logic [REV_W-1:0] rev_o,
  output logic             dir_o,
  output logic             rovr_o,
  output logic             rund_o
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [REV_W-1:0] rev_q, rev_d;
  logic             dir_q, dir_d;
  logic             at_top;
  logic             at_bot;

  always_comb begin
    at_top = mod_en_i ? (pos_q == mod_i)  : (&pos_q);
    at_bot = mod_en_i ? (pos_q == init_i) : (pos_q == '0);
    pos_d  = pos_q;
    dir_d  = dir_q;
    rovr_o = 1'b0;
    rund_o = 1'b0;
    if (load_i) begin
      pos_d = init_i;
    end else if (up_i) begin
      dir_d = 1'b1;
      if (at_top) begin
        rovr_o = 1'b1;
        pos_d  = mod_en_i ? init_i : '0;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end else if (dn_i) begin
      dir_d = 1'b0;
      if (at_bot) begin
        rund_o = 1'b1;
        pos_d  = mod_en_i ? mod_i : '1;
      end else begin
        pos_d = pos_q - 1'b1;
      end
    end
    rev_d = rev_q;
    if (rev_src_i) begin
      if (rovr_o)      rev_d = rev_q + 1'b1;
      else if (rund_o) rev_d = rev_q - 1'b1;
    end else if (index_i) begin
      rev_d = dir_q ? rev_q + 1'b1 : rev_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      rev_q <= '0;
      dir_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      rev_q <= rev_d;
      dir_q <= dir_d;
    end
  end

  assign pos_o = pos_q;
  assign rev_o = rev_q;
  assign dir_o = dir_q;

  p_load_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pos_q == $past(init_i)));

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && up_i && !mod_en_i) |=> (pos_q == $past(pos_q) + POS_W'(1)));

  p_mod_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && up_i && mod_en_i && (pos_q == mod_i)) |=> (pos_q == $past(init_i)));

endmodule

// File: rtl/qdec_watchdog.sv
module qdec_watchdog #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             activity_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (!en_i || activity_i) begin
      cnt_d = '0;
    end else if (cnt_q == tmo_i) begin
      expire_o = 1'b1;
      cnt_d    = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_wdog_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
  import qdec_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             home_in,
  input  logic             index_in,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             match_out,
  output logic             irq_out
);

  localparam int unsigned POS_W = 2 * REG_W;

  cfg_t             cfg_q, cfg_d;
  logic [NFLAG-1:0] ien_q, ien_d;
  logic [NFLAG-1:0] flags_q, flags_d;
  logic [NFLAG-1:0] set_vec, clr_vec;
  logic [POS_W-1:0] init_q, init_d;
  logic [POS_W-1:0] mod_q, mod_d;
  logic [POS_W-1:0] cmp_q, cmp_d;
  logic [POS_W-1:0] hold_q, hold_d;
  logic [REG_W-1:0] tmo_q, tmo_d;
  logic             match_q, match_d;

  logic             wr_cfg, wr_flags, wr_ien, wr_tmo;
  logic             wr_init_hi, wr_init_lo, wr_mod_hi, wr_mod_lo;
  logic             wr_cmp_hi, wr_cmp_lo;
  logic             swinit, pos_rd, cap_hold;

  logic             step_up, step_dn, simult, activity;
  logic             home_evt, index_evt, wdog_exp;
  logic             rovr, rund, dir;
  logic [POS_W-1:0] pos;
  logic [REG_W-1:0] rev;

  // ---------------- write / read strobes ----------------
  always_comb begin
    wr_cfg     = reg_wr && (reg_addr == AD_CFG);
    wr_flags   = reg_wr && (reg_addr == AD_FLAGS);
    wr_ien     = reg_wr && (reg_addr == AD_IEN);
    wr_tmo     = reg_wr && (reg_addr == AD_TMO);
    wr_init_hi = reg_wr && (reg_addr == AD_INIT_HI);
    wr_init_lo = reg_wr && (reg_addr == AD_INIT_LO);
    wr_mod_hi  = reg_wr && (reg_addr == AD_MOD_HI);
    wr_mod_lo  = reg_wr && (reg_addr == AD_MOD_LO);
    wr_cmp_hi  = reg_wr && (reg_addr == AD_CMP_HI);
    wr_cmp_lo  = reg_wr && (reg_addr == AD_CMP_LO);
    swinit     = wr_cfg && reg_wdata[SWINIT_BIT];
    cap_hold   = reg_rd && (reg_addr == AD_POS_HI);
    pos_rd     = reg_rd && ((reg_addr == AD_POS_HI) || (reg_addr == AD_HOLD_LO) ||
                            (reg_addr == AD_POS_LO) || (reg_addr == AD_HOLD_HI));
  end

  // ---------------- datapath sub-blocks ----------------
  qdec_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_i        (enc_a),
    .b_i        (enc_b),
    .single_i   (cfg_q.single),
    .reverse_i  (cfg_q.reverse),
    .up_o       (step_up),
    .dn_o       (step_dn),
    .simult_o   (simult),
    .activity_o (activity)
  );

  qdec_trig u_home (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (home_in),
    .mode_i (cfg_q.home_mode),
    .evt_o  (home_evt)
  );

  qdec_trig u_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (index_in),
    .mode_i (cfg_q.index_mode),
    .evt_o  (index_evt)
  );

  qdec_counter #(
    .POS_W (POS_W),
    .REV_W (REG_W)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (swinit | index_evt),
    .init_i    (init_q),
    .mod_i     (mod_q),
    .mod_en_i  (cfg_q.modulo),
    .up_i      (step_up),
    .dn_i      (step_dn),
    .index_i   (index_evt),
    .rev_src_i (cfg_q.rev_from_wrap),
    .pos_o     (pos),
    .rev_o     (rev),
    .dir_o     (dir),
    .rovr_o    (rovr),
    .rund_o    (rund)
  );

  qdec_watchdog #(
    .CNT_W (REG_W)
  ) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (cfg_q.wdog_en),
    .activity_i (activity),
    .tmo_i      (tmo_q),
    .expire_o   (wdog_exp)
  );

  // ---------------- register next state ----------------
  always_comb begin
    cfg_d  = wr_cfg ? cfg_t'(reg_wdata[CFG_W-1:0]) : cfg_q;
    ien_d  = wr_ien ? reg_wdata[NFLAG-1:0] : ien_q;
    tmo_d  = wr_tmo ? reg_wdata : tmo_q;
    init_d = init_q;
    mod_d  = mod_q;
    cmp_d  = cmp_q;
    if (wr_init_hi) init_d[POS_W-1:REG_W] = reg_wdata;
    if (wr_init_lo) init_d[REG_W-1:0]     = reg_wdata;
    if (wr_mod_hi)  mod_d[POS_W-1:REG_W]  = reg_wdata;
    if (wr_mod_lo)  mod_d[REG_W-1:0]      = reg_wdata;
    if (wr_cmp_hi)  cmp_d[POS_W-1:REG_W]  = reg_wdata;
    if (wr_cmp_lo)  cmp_d[REG_W-1:0]      = reg_wdata;
    hold_d = cap_hold ? pos : hold_q;

    set_vec           = '0;
    set_vec[FL_HOME]  = home_evt;
    set_vec[FL_INDEX] = index_evt;
    set_vec[FL_WDOG]  = wdog_exp;
    set_vec[FL_CMP]   = (pos == cmp_q);
    set_vec[FL_ROVR]  = rovr;
    set_vec[FL_RUND]  = rund;
    set_vec[FL_SIMUL] = simult;
    clr_vec           = wr_flags ? reg_wdata[NFLAG-1:0] : '0;
    flags_d           = (flags_q & ~clr_vec) | set_vec;

    match_d = cfg_q.match_on_read ? pos_rd : (pos == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ien_q   <= '0;
      flags_q <= '0;
      init_q  <= '0;
      mod_q   <= '0;
      cmp_q   <= '1;
      hold_q  <= '0;
      tmo_q   <= '0;
      match_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      ien_q   <= ien_d;
      flags_q <= flags_d;
      init_q  <= init_d;
      mod_q   <= mod_d;
      cmp_q   <= cmp_d;
      hold_q  <= hold_d;
      tmo_q   <= tmo_d;
      match_q <= match_d;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AD_CFG:     reg_rdata[CFG_W-1:0] = cfg_q;
      AD_FLAGS: begin
        reg_rdata[NFLAG-1:0] = flags_q;
        reg_rdata[DIR_BIT]   = dir;
      end
      AD_IEN:     reg_rdata[NFLAG-1:0] = ien_q;
      AD_POS_HI:  reg_rdata = pos[POS_W-1:REG_W];
      AD_HOLD_LO: reg_rdata = hold_q[REG_W-1:0];
      AD_POS_LO:  reg_rdata = pos[REG_W-1:0];
      AD_REV:     reg_rdata = rev;
      AD_INIT_HI: reg_rdata = init_q[POS_W-1:REG_W];
      AD_INIT_LO: reg_rdata = init_q[REG_W-1:0];
      AD_MOD_HI:  reg_rdata = mod_q[POS_W-1:REG_W];
      AD_MOD_LO:  reg_rdata = mod_q[REG_W-1:0];
      AD_CMP_HI:  reg_rdata = cmp_q[POS_W-1:REG_W];
      AD_CMP_LO:  reg_rdata = cmp_q[REG_W-1:0];
      AD_TMO:     reg_rdata = tmo_q;
      AD_HOLD_HI: reg_rdata = hold_q[POS_W-1:REG_W];
      default:    reg_rdata = '0;
    endcase
  end

  assign match_out = match_q;
  assign irq_out   = |(flags_q & ien_q);

  // a flag not written with one keeps its value
  p_w1c_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0) |=> ((flags_q & $past(flags_q & ~clr_vec)) == $past(flags_q & ~clr_vec)));

  p_hold_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hold |=> (hold_q == $past(pos)));

endmodule

// File: tb/test_quad_pos_decoder.sv
module test_quad_pos_decoder;

  localparam logic [3:0] A_CFG = 4'd0, A_FLG = 4'd1, A_IEN = 4'd2, A_PHI = 4'd3,
                         A_HLO = 4'd4, A_PLO = 4'd5, A_REV = 4'd6, A_IHI = 4'd7,
                         A_ILO = 4'd8, A_MHI = 4'd9, A_MLO = 4'd10, A_CHI = 4'd11,
                         A_CLO = 4'd12, A_TMO = 4'd13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, home_in = 1'b0, index_in = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        match_out, irq_out;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  quad_pos_decoder i_quad_pos_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_a     (enc_a),
    .enc_b     (enc_b),
    .home_in   (home_in),
    .index_in  (index_in),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .match_out (match_out),
    .irq_out   (irq_out)
  );

  // monitor: pops one expected item for every read it sees
  always @(negedge clk) begin
    if (reg_rd) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: read with no expected item, act=%h exp=none", reg_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (reg_rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s: act=%h exp=%h", e.tag, reg_rdata, e.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    exp_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic ab(input logic a, input logic b);
    @(posedge clk); #1;
    enc_a = a; enc_b = b;
  endtask

  task automatic hm(input logic v);
    @(posedge clk); #1;
    home_in = v;
  endtask

  task automatic ix(input logic v);
    @(posedge clk); #1;
    index_in = v;
  endtask

  task automatic chk(input string tag, input logic act, input logic e);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b", tag, act, e);
    end
  endtask

  initial begin
    #1_600_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 match", match_out, 1'b0);
    chk("R1 irq", irq_out, 1'b0);
    rd(A_PHI, 16'h0000, "R1 pos hi");
    rd(A_HLO, 16'h0000, "R1 hold lo");
    rd(A_FLG, 16'h0000, "R1 flags");
    rd(A_CHI, 16'hFFFF, "R1 cmp hi");
    rd(A_CLO, 16'hFFFF, "R1 cmp lo");
    rd(A_REV, 16'h0000, "R1 rev");

    // R2 quadrature up then down
    ab(1,0); ab(1,1); ab(0,1); ab(0,0);
    rd(A_PHI, 16'h0000, "R2 pos hi");
    rd(A_HLO, 16'h0004, "R2 up four");
    rd(A_FLG, 16'h0100, "R2 dir up");
    ab(0,1); ab(1,1);
    rd(A_PLO, 16'h0002, "R2 down two");
    rd(A_FLG, 16'h0000, "R2 dir down");

    // R3 both phases change; R12 and R13 on that flag
    ab(0,0);
    rd(A_FLG, 16'h0040, "R3 simult flag");
    rd(A_PLO, 16'h0002, "R3 no count");
    wr(A_IEN, 16'h0040);
    chk("R13 irq on", irq_out, 1'b1);
    wr(A_FLG, 16'h0000);
    rd(A_FLG, 16'h0040, "R12 write zero keeps");
    wr(A_IEN, 16'h0000);
    chk("R13 irq masked", irq_out, 1'b0);
    wr(A_FLG, 16'h0040);
    rd(A_FLG, 16'h0000, "R12 write one clears");

    // R4 reverse
    wr(A_CFG, 16'h0001);
    ab(1,0);
    rd(A_PLO, 16'h0001, "R4 reversed step");
    wr(A_CFG, 16'h0000);

    // R5 single phase
    wr(A_CFG, 16'h0002);
    ab(0,0); ab(1,0);
    rd(A_PLO, 16'h0002, "R5 A rise B low");
    ab(1,1);
    rd(A_PLO, 16'h0002, "R5 B alone");
    ab(0,1); ab(1,1);
    rd(A_PLO, 16'h0001, "R5 A rise B high");
    wr(A_CFG, 16'h0000);

    // R6 home edges
    wr(A_CFG, 16'h0004);
    hm(1'b1);
    rd(A_FLG, 16'h0001, "R6 rising set");
    wr(A_FLG, 16'h0001);
    hm(1'b0);
    rd(A_FLG, 16'h0000, "R6 falling ignored");
    wr(A_CFG, 16'h0008);
    hm(1'b1);
    rd(A_FLG, 16'h0000, "R6 rising ignored");
    hm(1'b0);
    rd(A_FLG, 16'h0001, "R6 falling set");
    wr(A_FLG, 16'h0001);
    wr(A_CFG, 16'h0000);
    hm(1'b1); hm(1'b0);
    rd(A_FLG, 16'h0000, "R6 disabled");

    // R7 index
    ab(0,1);
    wr(A_IHI, 16'h0001);
    wr(A_ILO, 16'h0005);
    wr(A_CFG, 16'h0010);
    ix(1'b1);
    rd(A_PHI, 16'h0001, "R7 load hi");
    rd(A_HLO, 16'h0005, "R7 load lo");
    rd(A_REV, 16'h0001, "R7 rev up");
    rd(A_FLG, 16'h0102, "R7 index flag");
    ix(1'b0);
    wr(A_FLG, 16'h0002);
    wr(A_CFG, 16'h0020);
    ix(1'b1);
    rd(A_REV, 16'h0001, "R7 falling mode ignores rise");
    ix(1'b0);
    rd(A_REV, 16'h0002, "R7 falling edge");
    wr(A_FLG, 16'h0002);
    wr(A_CFG, 16'h0000);

    // R14 software load
    ab(0,0);
    rd(A_PLO, 16'h0006, "R14 before load");
    wr(A_CFG, 16'h8000);
    rd(A_PHI, 16'h0001, "R14 load hi");
    rd(A_HLO, 16'h0005, "R14 load lo");
    rd(A_CFG, 16'h0000, "R14 bit reads zero");

    // R8 modulo window 0x10005..0x10007
    wr(A_MHI, 16'h0001);
    wr(A_MLO, 16'h0007);
    wr(A_CFG, 16'h0040);
    ab(1,0); ab(1,1); ab(0,1);
    rd(A_PLO, 16'h0005, "R8 wrap up to init");
    rd(A_FLG, 16'h0110, "R8 roll-over flag");
    wr(A_FLG, 16'h0010);
    ab(1,1);
    rd(A_PLO, 16'h0007, "R8 wrap down to modulus");
    rd(A_FLG, 16'h0020, "R8 roll-under flag");
    wr(A_FLG, 16'h0020);
    rd(A_REV, 16'h0002, "R8 index source ignores wraps");
    wr(A_CFG, 16'h00C0);
    ab(0,1);
    rd(A_REV, 16'h0003, "R8 wrap source");
    wr(A_FLG, 16'h0010);

    // R8 plain wrap, R9 and R12 collision at all-ones compare
    wr(A_CFG, 16'h0000);
    wr(A_IHI, 16'h0000);
    wr(A_ILO, 16'h0000);
    wr(A_CFG, 16'h8000);
    ab(1,1);
    rd(A_PHI, 16'hFFFF, "R8 under zero hi");
    rd(A_HLO, 16'hFFFF, "R8 under zero lo");
    rd(A_FLG, 16'h0028, "R8 roll-under and R9 compare");
    chk("R9 match level", match_out, 1'b1);
    wr(A_FLG, 16'h0028);
    ab(0,1);
    rd(A_FLG, 16'h0118, "R12 set wins over clear");
    wr(A_FLG, 16'h0018);
    rd(A_FLG, 16'h0100, "R12 cleared");

    // R9 compare equal and read-pulse modes
    wr(A_CHI, 16'h0000);
    wr(A_CLO, 16'h0002);
    ab(0,0); ab(1,0);
    tick();
    chk("R9 match one cycle late", match_out, 1'b0);
    tick();
    chk("R9 match on equal", match_out, 1'b1);
    ab(1,1);
    tick(); tick();
    chk("R9 match drops", match_out, 1'b0);
    rd(A_FLG, 16'h0108, "R9 compare flag");
    wr(A_FLG, 16'h0008);
    wr(A_CFG, 16'h0100);
    rd(A_PLO, 16'h0003, "R9 read mode pos");
    chk("R9 read pulse", match_out, 1'b1);
    tick();
    chk("R9 read pulse ends", match_out, 1'b0);
    wr(A_CFG, 16'h0000);

    // R10 hold coherence
    rd(A_PHI, 16'h0000, "R10 capture");
    ab(0,1);
    rd(A_HLO, 16'h0003, "R10 held lower");
    rd(A_PLO, 16'h0004, "R10 live lower");

    // R11 watchdog
    wr(A_IEN, 16'h0004);
    wr(A_TMO, 16'h0005);
    wr(A_CFG, 16'h0200);
    repeat (5) tick();
    chk("R11 not yet", irq_out, 1'b0);
    tick();
    chk("R11 expired", irq_out, 1'b1);
    wr(A_FLG, 16'h0004);
    for (int i = 0; i < 4; i++) begin
      ab(i[0] ? 1'b0 : 1'b1, 1'b1);
      tick(); tick();
    end
    chk("R11 activity restarts", irq_out, 1'b0);
    wr(A_CFG, 16'h0000);
    repeat (10) tick();
    chk("R11 disabled", irq_out, 1'b0);

    if (sb_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: act=%0d left exp=0", sb_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule